// File: doc/BRIEF.md
# Alignment-Aware Burst Splitter

This block sits between a DMA channel scheduler and a memory bus. It takes one burst request, which holds a byte address, a byte length and a channel number. It turns that request into one or two bus commands, each with an address, a length and a transaction ID. A command never crosses a boundary that is a multiple of the maximum burst size. When a request runs past such a boundary, the block issues two commands in address order. The first ends at the boundary and the second begins there.

The channel number goes into the low bits of the transaction ID, and the upper ID bits are zero. Several channels can therefore have commands in flight on the bus, and responses can be matched back to their channel. The request side and the command side each use a valid/ready handshake.

A request with a length of zero, or a length larger than the maximum burst, is accepted and dropped. The block then raises a one-cycle error pulse.

A four-state machine controls the block:
- `S_IDLE` is ready for a request.
- `S_SINGLE` holds a command that fits entirely before a boundary.
- `S_HEAD` holds the first part of a split.
- `S_TAIL` holds the second part.

Its transitions are:
- `S_IDLE -> S_SINGLE` on a valid request that does not cross a boundary.
- `S_IDLE -> S_HEAD` on a valid request that crosses a boundary.
- `S_IDLE -> S_IDLE` on a rejected request, which raises the error pulse, or when no request is present.
- `S_SINGLE -> S_IDLE` when the command is taken.
- `S_HEAD -> S_TAIL` when the first part is taken.
- `S_TAIL -> S_IDLE` when the second part is taken.
- Every other state stays where it is while `cmd_ready` is low.

Top module: `burst_splitter`

## Requirements
- R1: After reset, `cmd_valid` is 0, `req_ready` is 1 and `req_err` is 0.
- R2: A request with offset = `req_addr mod MAX_BURST_BYTES` and offset + `req_len` <= `MAX_BURST_BYTES` produces exactly one command, with `cmd_addr` = `req_addr` and `cmd_len` = `req_len`.
- R3: A request with offset + `req_len` > `MAX_BURST_BYTES` produces two commands. The first has `cmd_addr` = `req_addr` and `cmd_len` = `MAX_BURST_BYTES` - offset.
- R4: The second command of a split follows the first. Its `cmd_addr` is the next multiple of `MAX_BURST_BYTES` above `req_addr`, modulo 2^ADDR_W. Its `cmd_len` is `req_len` minus the first command's length.
- R5: Every command carries the request's channel number in `cmd_id[CH_W-1:0]`, and the upper bits of `cmd_id` are 0. Both parts of a split carry the same ID.
- R6: `req_ready` is 1 exactly when no command is held. It stays 0 until the last command of the current request has been accepted.
- R7: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_addr`, `cmd_len` and `cmd_id` hold their values.
- R8: A request with `req_len` = 0 or `req_len` > `MAX_BURST_BYTES` produces no command. It raises `req_err` for exactly one cycle, starting in the cycle after the request is accepted.
- R9: Every command has 1 <= `cmd_len` <= `MAX_BURST_BYTES`, and (`cmd_addr mod MAX_BURST_BYTES`) + `cmd_len` <= `MAX_BURST_BYTES`.
- R10: The first command of a request is valid in the cycle right after the request is accepted. The second part of a split is valid in the cycle right after the first part is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A burst request is offered |
| req_ready | output | 1 | The block can take a request |
| req_addr | input | ADDR_W | Byte address of the burst |
| req_len | input | REQ_LEN_W | Burst length in bytes |
| req_chan | input | CH_W | Channel number |
| req_err | output | 1 | One-cycle pulse marking a rejected request |
| cmd_valid | output | 1 | A bus command is offered |
| cmd_ready | input | 1 | The bus takes the command |
| cmd_addr | output | ADDR_W | Byte address of the command |
| cmd_len | output | CMD_LEN_W | Byte length of the command |
| cmd_id | output | ID_W | Transaction ID, channel number in the low bits |

## Verification
All results come from registers, so each one appears one cycle after the clock edge that caused it. A command, or a rejection pulse, appears at the edge after the request handshake. A split's second part appears at the edge after the first part's handshake. The bench drives inputs on falling edges and checks outputs on the next falling edge. Because outputs are registered, every check falls half a cycle after the edge that produced the result. It holds `cmd_ready` low for a random number of cycles and checks the held command and `req_ready` on each of those cycles. This confirms that nothing moves until the handshake.

// File: rtl/split_pkg.sv
package split_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SINGLE = 2'd1,
        S_HEAD   = 2'd2,
        S_TAIL   = 2'd3
    } split_state_t;

endpackage

// File: rtl/split_calc.sv
module split_calc #(
    parameter int ADDR_W          = 32,
    parameter int MAX_BURST_BYTES = 64,
    parameter int REQ_LEN_W       = 8,
    parameter int CMD_LEN_W       = 7
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [REQ_LEN_W-1:0] len,
    output logic                 bad,
    output logic                 crosses,
    output logic [CMD_LEN_W-1:0] head_len,
    output logic [ADDR_W-1:0]    tail_addr,
    output logic [CMD_LEN_W-1:0] tail_len
);
    localparam int OFF_W = $clog2(MAX_BURST_BYTES);
    localparam int HI_W  = ADDR_W - OFF_W;

    logic [OFF_W-1:0]   offset;
    logic [REQ_LEN_W:0] reach;
    logic [HI_W-1:0]    next_hi;

    assign offset  = addr[OFF_W-1:0];
    assign reach   = {1'b0, len} + (REQ_LEN_W+1)'(offset);
    assign bad     = (len == '0) || (len > REQ_LEN_W'(MAX_BURST_BYTES));
    assign crosses = !bad && (reach > (REQ_LEN_W+1)'(MAX_BURST_BYTES));

    assign head_len  = CMD_LEN_W'(MAX_BURST_BYTES) - CMD_LEN_W'(offset);
    assign next_hi   = addr[ADDR_W-1:OFF_W] + HI_W'(1);
    assign tail_addr = {next_hi, {OFF_W{1'b0}}};
    assign tail_len  = CMD_LEN_W'(len) - head_len;
endmodule

// File: rtl/split_ctrl.sv
module split_ctrl
    import split_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CH_W      = 3,
    parameter int CMD_LEN_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [CH_W-1:0]      req_chan,
    input  logic [CMD_LEN_W-1:0] req_len_fit,
    input  logic                 bad,
    input  logic                 crosses,
    input  logic [CMD_LEN_W-1:0] head_len,
    input  logic [ADDR_W-1:0]    tail_addr,
    input  logic [CMD_LEN_W-1:0] tail_len,
    input  logic                 cmd_ready,
    output logic                 req_ready,
    output logic                 req_err,
    output logic                 cmd_valid,
    output logic [ADDR_W-1:0]    cmd_addr,
    output logic [CMD_LEN_W-1:0] cmd_len,
    output logic [CH_W-1:0]      cmd_chan
);
    split_state_t state, state_nx;

    logic                 take;
    logic                 err_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [CMD_LEN_W-1:0] len_q;
    logic [CH_W-1:0]      chan_q;
    logic [ADDR_W-1:0]    rest_addr_q;
    logic [CMD_LEN_W-1:0] rest_len_q;

    assign take = (state == S_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid && !bad) state_nx = crosses ? S_HEAD : S_SINGLE;
            end
            S_SINGLE: if (cmd_ready) state_nx = S_IDLE;
            S_HEAD:   if (cmd_ready) state_nx = S_TAIL;
            S_TAIL:   if (cmd_ready) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        cmd_valid = 1'b0;
        unique case (state)
            S_IDLE:                   req_ready = 1'b1;
            S_SINGLE, S_HEAD, S_TAIL: cmd_valid = 1'b1;
            default:                  req_ready = 1'b0;
        endcase
    end

    assign req_err  = err_q;
    assign cmd_addr = addr_q;
    assign cmd_len  = len_q;
    assign cmd_chan = chan_q;

    // command and remainder registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q       <= 1'b0;
            addr_q      <= '0;
            len_q       <= '0;
            chan_q      <= '0;
            rest_addr_q <= '0;
            rest_len_q  <= '0;
        end else begin
            err_q <= take && bad;
            if (take && !bad) begin
                addr_q      <= req_addr;
                len_q       <= crosses ? head_len : req_len_fit;
                chan_q      <= req_chan;
                rest_addr_q <= tail_addr;
                rest_len_q  <= tail_len;
            end else if (state == S_HEAD && cmd_ready) begin
                addr_q <= rest_addr_q;
                len_q  <= rest_len_q;
            end
        end
    end
endmodule

// File: rtl/burst_splitter.sv
module burst_splitter #(
    parameter int ADDR_W          = 32,
    parameter int MAX_BURST_BYTES = 64,
    parameter int REQ_LEN_W       = 8,
    parameter int CH_W            = 3,
    parameter int ID_W            = 4,
    localparam int CMD_LEN_W      = $clog2(MAX_BURST_BYTES) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [REQ_LEN_W-1:0] req_len,
    input  logic [CH_W-1:0]      req_chan,
    output logic                 req_err,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic [ADDR_W-1:0]    cmd_addr,
    output logic [CMD_LEN_W-1:0] cmd_len,
    output logic [ID_W-1:0]      cmd_id
);
    initial begin
        if (MAX_BURST_BYTES < 2 || MAX_BURST_BYTES > 64 ||
            (MAX_BURST_BYTES & (MAX_BURST_BYTES - 1)) != 0)
            $error("MAX_BURST_BYTES must be a power of two from 2 to 64");
        if (REQ_LEN_W < CMD_LEN_W) $error("REQ_LEN_W too narrow");
        if (ID_W < CH_W)           $error("ID_W must hold the channel number");
    end

    logic                 bad, crosses;
    logic [CMD_LEN_W-1:0] head_len, tail_len;
    logic [ADDR_W-1:0]    tail_addr;
    logic [CH_W-1:0]      cmd_chan;

    split_calc #(
        .ADDR_W(ADDR_W), .MAX_BURST_BYTES(MAX_BURST_BYTES),
        .REQ_LEN_W(REQ_LEN_W), .CMD_LEN_W(CMD_LEN_W)
    ) u_calc (
        .addr(req_addr), .len(req_len), .bad(bad), .crosses(crosses),
        .head_len(head_len), .tail_addr(tail_addr), .tail_len(tail_len)
    );

    split_ctrl #(
        .ADDR_W(ADDR_W), .CH_W(CH_W), .CMD_LEN_W(CMD_LEN_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_addr(req_addr), .req_chan(req_chan),
        .req_len_fit(req_len[CMD_LEN_W-1:0]),
        .bad(bad), .crosses(crosses), .head_len(head_len),
        .tail_addr(tail_addr), .tail_len(tail_len),
        .cmd_ready(cmd_ready), .req_ready(req_ready), .req_err(req_err),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .cmd_chan(cmd_chan)
    );

    generate
        if (ID_W > CH_W) begin : g_id_pad
            assign cmd_id = {{(ID_W-CH_W){1'b0}}, cmd_chan};
        end else begin : g_id_exact
            assign cmd_id = cmd_chan;
        end
    endgenerate
endmodule

// File: rtl/split_checker.sv
module split_checker #(
    parameter int ADDR_W          = 32,
    parameter int MAX_BURST_BYTES = 64,
    parameter int REQ_LEN_W       = 8,
    parameter int CH_W            = 3,
    parameter int ID_W            = 4,
    parameter int CMD_LEN_W       = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_err,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic [ADDR_W-1:0]    cmd_addr,
    input logic [CMD_LEN_W-1:0] cmd_len,
    input logic [ID_W-1:0]      cmd_id
);
    localparam int OFF_W = $clog2(MAX_BURST_BYTES);

    logic [CMD_LEN_W:0] cmd_reach;
    assign cmd_reach = (CMD_LEN_W+1)'(cmd_addr[OFF_W-1:0]) + {1'b0, cmd_len};

    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready != cmd_valid); // R6

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr)
            && $stable(cmd_len) && $stable(cmd_id)); // R7

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_len != '0 && cmd_len <= CMD_LEN_W'(MAX_BURST_BYTES)); // R9

    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_reach <= (CMD_LEN_W+1)'(MAX_BURST_BYTES)); // R9

    AST_ERR_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> req_err || cmd_valid); // R10

    AST_ERR_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !cmd_valid); // R8
endmodule

bind burst_splitter split_checker #(
    .ADDR_W(ADDR_W), .MAX_BURST_BYTES(MAX_BURST_BYTES), .REQ_LEN_W(REQ_LEN_W),
    .CH_W(CH_W), .ID_W(ID_W), .CMD_LEN_W(CMD_LEN_W)
) u_split_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_err(req_err), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_id(cmd_id)
);

// File: tb/burst_splitter_test.sv
`timescale 1ns/1ps
module burst_splitter_test;
    localparam int ADDR_W = 32;
    localparam int MAXB   = 64;
    localparam int LW     = 8;
    localparam int CH_W   = 3;
    localparam int ID_W   = 4;
    localparam int CLW    = $clog2(MAXB) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LW-1:0]     req_len = '0;
    logic [CH_W-1:0]   req_chan = '0;
    logic              req_err;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic [ADDR_W-1:0] cmd_addr;
    logic [CLW-1:0]    cmd_len;
    logic [ID_W-1:0]   cmd_id;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    burst_splitter #(.ADDR_W(ADDR_W), .MAX_BURST_BYTES(MAXB), .REQ_LEN_W(LW),
                     .CH_W(CH_W), .ID_W(ID_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_chan(req_chan),
        .req_err(req_err), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_id(cmd_id)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int off_of(input logic [ADDR_W-1:0] a);
        return int'(a % MAXB);
    endfunction

    function automatic logic [ADDR_W-1:0] next_bound(input logic [ADDR_W-1:0] a);
        return a - ADDR_W'(off_of(a)) + ADDR_W'(MAXB);
    endfunction

    task automatic expect_cmd(input string tag, input logic [ADDR_W-1:0] a,
                              input int l, input logic [CH_W-1:0] ch);
        int stall;
        stall = $urandom % 3;
        for (int s = 0; s <= stall; s++) begin
            if (s == stall) cmd_ready = 1'b1;
            check({tag, " R10 valid"}, 64'(cmd_valid), 64'd1);
            check("R6 ready low while busy", 64'(req_ready), 64'd0);
            check({tag, " addr (R7)"}, 64'(cmd_addr), 64'(a));
            check({tag, " len (R7)"}, 64'(cmd_len), 64'(l));
            check("R5 id", 64'(cmd_id), 64'(ch));
            @(negedge clk);
        end
        cmd_ready = 1'b0;
    endtask

    task automatic do_req(input logic [ADDR_W-1:0] a, input int l, input logic [CH_W-1:0] ch);
        int off;
        @(negedge clk);
        check("R6 ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_addr = a; req_len = LW'(l); req_chan = ch;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = ADDR_W'($urandom); req_len = LW'($urandom); req_chan = CH_W'($urandom);
        off = off_of(a);
        if (l == 0 || l > MAXB) begin
            check("R8 err pulse", 64'(req_err), 64'd1);
            check("R8 no command", 64'(cmd_valid), 64'd0);
            @(negedge clk);
            check("R8 err one cycle", 64'(req_err), 64'd0);
            check("R8 still no command", 64'(cmd_valid), 64'd0);
        end else if (off + l <= MAXB) begin
            check("R8 no err", 64'(req_err), 64'd0);
            expect_cmd("R2 single", a, l, ch);
        end else begin
            check("R8 no err", 64'(req_err), 64'd0);
            expect_cmd("R3 head", a, MAXB - off, ch);
            expect_cmd("R4 tail", next_bound(a), l - (MAXB - off), ch);
        end
        check("R2 R4 no extra command", 64'(cmd_valid), 64'd0);
        check("R6 ready after done", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250117));
        repeat (3) @(negedge clk);
        check("R1 cmd_valid", 64'(cmd_valid), 64'd0);
        check("R1 req_ready", 64'(req_ready), 64'd1);
        check("R1 req_err", 64'(req_err), 64'd0);
        rst_n = 1'b1;
        // directed corners
        do_req(32'h0000_1000, MAXB, 3'd5);         // aligned full
        do_req(32'h0000_103F, 2, 3'd1);            // last byte, crosses
        do_req(32'h0000_2001, MAXB, 3'd7);         // offset 1, max length
        do_req(32'h0000_207F, 1, 3'd2);            // last byte, fits
        do_req(32'h0000_3010, 48, 3'd4);           // ends exactly on boundary
        do_req(32'hFFFF_FFF0, 32, 3'd6);           // tail wraps to 0
        do_req(32'h0000_4000, 0, 3'd3);            // zero length
        do_req(32'h0000_4000, MAXB + 1, 3'd0);     // oversize
        do_req(32'h0000_4004, 255, 3'd0);          // max oversize
        for (int i = 0; i < 300; i++) begin
            int l;
            int pick;
            pick = $urandom % 20;
            if (pick == 0)      l = 0;
            else if (pick == 1) l = MAXB + 1 + ($urandom % (255 - MAXB));
            else                l = 1 + ($urandom % MAXB);
            do_req(ADDR_W'($urandom), l, CH_W'($urandom));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule